// File: doc/BRIEF.md
# Terminal-Count Pulse-Width Modulator

This block produces a pulse-width-modulated waveform without any magnitude comparator. Two loadable down counters do the timing: a frame counter whose borrow marks the end of each PWM period, and a duty counter whose borrow marks the end of the high phase. A set/reset output flop is set by the frame borrow and cleared by the duty borrow. Both borrows come straight out of each counter's decrementer, so no equality logic sits on the count value.

The period and mark words are written into staging registers through two write strobes. The counters only read the staging registers when the frame counter reloads, so a write never disturbs the frame in progress. A one-cycle frame-start strobe marks the first cycle of every frame, and an enable input freezes the whole timing chain when low.

Top module: `pwm_tc_gen`

## Requirements
- R1: Synchronous reset drives `pwm_out` and `frame_start` low and loads the staging registers with `RST_PERIOD` (default 9) and `RST_MARK` (default 3); the first enabled cycle after reset starts a frame, so `frame_start` is high one cycle later.
- R2: Each frame lasts exactly period+1 enabled cycles, and `frame_start` is high only during the first cycle of each frame.
- R3: For a mark M with 1 <= M <= period, `pwm_out` is high during the first M cycles of the frame and low for the rest.
- R4: A mark of zero keeps `pwm_out` low for the whole frame.
- R5: A mark greater than the period keeps `pwm_out` high for the whole frame; the frame reload takes precedence over the duty clear.
- R6: A write to the period or mark staging register during a frame leaves that frame unchanged; the new value governs the frames that start after the next reload.
- R7: While `en` is low, `pwm_out` and both counters hold, no frame starts, and the frame is stretched by the number of disabled cycles.
- R8: Once `pwm_out` falls within a frame it stays low until the next frame start; the duty counter holds at zero instead of wrapping.
- R9: A period of zero makes every enabled cycle a frame of one cycle, with `pwm_out` high exactly when the mark is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable; low freezes counters and output |
| wr_period | input | 1 | Write strobe for the period staging register |
| period_in | input | CNT_W | Period value; frame length is this plus one |
| wr_mark | input | 1 | Write strobe for the mark staging register |
| mark_in | input | CNT_W | Mark value; high time in cycles |
| pwm_out | output | 1 | Modulated output from the set/reset flop |
| frame_start | output | 1 | High for the first cycle of each frame |

## Verification
The hardest situation to reach from the ports is a register write landing in the middle of a running frame, because the bench has to know exactly where the frame boundary lies before it writes. The stimulus first waits for a frame-start strobe, writes new period and mark values one cycle into the frame, measures that frame against the old settings, and then measures the following frame against the new ones. The other awkward corners, a mark beyond the period where the set and clear meet at one edge and a period of zero where every cycle reloads, are reached by directed settings before a seeded random sweep of period and mark pairs.

// File: rtl/pwm_tc_pkg.sv
package pwm_tc_pkg;

   // Behaviour of a down counter once it has reached zero and keeps stepping
   typedef enum logic {
      WRAP_ROLL = 1'b0,
      WRAP_HOLD = 1'b1
   } wrap_e;

endpackage

// File: rtl/pwm_tc_downcnt.sv
module pwm_tc_downcnt
   import pwm_tc_pkg::*;
#(
   parameter int unsigned W    = 8,
   parameter wrap_e       WRAP = WRAP_HOLD
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         step,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         tc
);

   localparam int unsigned DW = W + 1;

   logic [W-1:0]  count_q;
   logic [DW-1:0] diff;
   logic [W-1:0]  count_nxt;

   if (W < 1) begin : g_bad_width
      $error("pwm_tc_downcnt: W must be at least 1");
   end

   // Borrow out of the decrementer is the terminal count
   assign diff = {1'b0, count_q} - {{W{1'b0}}, 1'b1};
   assign tc   = diff[DW-1];

   if (WRAP == WRAP_HOLD) begin : g_hold
      assign count_nxt = tc ? '0 : diff[W-1:0];
   end else begin : g_roll
      assign count_nxt = diff[W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         count_q <= '0;
      end else if (load) begin
         count_q <= load_val;
      end else if (step) begin
         count_q <= count_nxt;
      end
   end

   p_load_takes_r2 : assert property (@(posedge clk) disable iff (rst)
      load |=> (count_q == $past(load_val)));

   if (WRAP == WRAP_HOLD) begin : g_hold_chk
      p_zero_sticks_r8 : assert property (@(posedge clk) disable iff (rst)
         (tc && step && !load) |=> tc);
   end

endmodule

// File: rtl/pwm_tc_cfgreg.sv
module pwm_tc_cfgreg #(
   parameter int unsigned    W       = 8,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] value
);

   always_ff @(posedge clk) begin
      if (rst) begin
         value <= RST_VAL;
      end else if (wr) begin
         value <= wdata;
      end
   end

   p_hold_unwritten_r6 : assert property (@(posedge clk) disable iff (rst)
      !wr |=> $stable(value));

endmodule

// File: rtl/pwm_tc_srflop.sv
module pwm_tc_srflop (
   input  logic clk,
   input  logic rst,
   input  logic set,
   input  logic set_val,
   input  logic clr,
   output logic q
);

   // Set (frame reload) wins over clear (duty borrow)
   always_ff @(posedge clk) begin
      if (rst) begin
         q <= 1'b0;
      end else if (set) begin
         q <= set_val;
      end else if (clr) begin
         q <= 1'b0;
      end
   end

   p_set_wins_r5 : assert property (@(posedge clk) disable iff (rst)
      (set && set_val) |=> q);

endmodule

// File: rtl/pwm_tc_gen.sv
module pwm_tc_gen
   import pwm_tc_pkg::*;
#(
   parameter int unsigned        CNT_W      = 8,
   parameter logic [CNT_W-1:0]   RST_PERIOD = 9,
   parameter logic [CNT_W-1:0]   RST_MARK   = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             wr_period,
   input  logic [CNT_W-1:0] period_in,
   input  logic             wr_mark,
   input  logic [CNT_W-1:0] mark_in,
   output logic             pwm_out,
   output logic             frame_start
);

   localparam int unsigned MW = CNT_W + 1;

   logic [CNT_W-1:0] period_q;
   logic [CNT_W-1:0] mark_q;
   logic [MW-1:0]    mark_dec;
   logic             mark_zero;
   logic [CNT_W-1:0] duty_seed;
   logic             frame_tc;
   logic             duty_tc;
   logic             frame_load;
   logic             duty_clr;
   logic             start_q;

   if (CNT_W < 2) begin : g_bad_width
      $error("pwm_tc_gen: CNT_W must be at least 2");
   end

   pwm_tc_cfgreg #(.W(CNT_W), .RST_VAL(RST_PERIOD)) u_period (
      .clk   (clk),
      .rst   (rst),
      .wr    (wr_period),
      .wdata (period_in),
      .value (period_q)
   );

   pwm_tc_cfgreg #(.W(CNT_W), .RST_VAL(RST_MARK)) u_mark (
      .clk   (clk),
      .rst   (rst),
      .wr    (wr_mark),
      .wdata (mark_in),
      .value (mark_q)
   );

   // Duty counter is seeded with mark-1 so its borrow ends the high phase
   // after exactly mark cycles; the same borrow flags a zero mark.
   assign mark_dec  = {1'b0, mark_q} - {{CNT_W{1'b0}}, 1'b1};
   assign mark_zero = mark_dec[MW-1];
   assign duty_seed = mark_zero ? '0 : mark_dec[CNT_W-1:0];

   assign frame_load = en & frame_tc;
   assign duty_clr   = en & duty_tc;

   pwm_tc_downcnt #(.W(CNT_W), .WRAP(WRAP_ROLL)) u_frame_cnt (
      .clk      (clk),
      .rst      (rst),
      .step     (en),
      .load     (frame_load),
      .load_val (period_q),
      .tc       (frame_tc)
   );

   pwm_tc_downcnt #(.W(CNT_W), .WRAP(WRAP_HOLD)) u_duty_cnt (
      .clk      (clk),
      .rst      (rst),
      .step     (en),
      .load     (frame_load),
      .load_val (duty_seed),
      .tc       (duty_tc)
   );

   pwm_tc_srflop u_out (
      .clk     (clk),
      .rst     (rst),
      .set     (frame_load),
      .set_val (~mark_zero),
      .clr     (duty_clr),
      .q       (pwm_out)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         start_q <= 1'b0;
      end else begin
         start_q <= frame_load;
      end
   end

   assign frame_start = start_q;

   p_reset_quiet_r1 : assert property (@(posedge clk)
      rst |=> (!pwm_out && !frame_start));

   p_idle_hold_r7 : assert property (@(posedge clk) disable iff (rst)
      !en |=> ($stable(pwm_out) && !frame_start));

   p_rise_only_at_start_r8 : assert property (@(posedge clk) disable iff (rst)
      $rose(pwm_out) |-> frame_start);

   p_start_needs_enable_r2 : assert property (@(posedge clk) disable iff (rst)
      frame_start |-> $past(en));

endmodule

// File: tb/test_pwm_tc_gen.sv
`timescale 1ns/1ps
module test_pwm_tc_gen;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         en = 1'b0;
   logic         wr_period = 1'b0;
   logic [W-1:0] period_in = '0;
   logic         wr_mark = 1'b0;
   logic [W-1:0] mark_in = '0;
   logic         pwm_out;
   logic         frame_start;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   pwm_tc_gen #(.CNT_W(W), .RST_PERIOD(8'd9), .RST_MARK(8'd3)) i_pwm_tc_gen (
      .clk         (clk),
      .rst         (rst),
      .en          (en),
      .wr_period   (wr_period),
      .period_in   (period_in),
      .wr_mark     (wr_mark),
      .mark_in     (mark_in),
      .pwm_out     (pwm_out),
      .frame_start (frame_start)
   );

   task automatic tick;
      @(negedge clk);
   endtask

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int exp_high(input int p, input int m);
      return (m > p) ? p + 1 : m;
   endfunction

   task automatic sync_frame;
      int guard = 0;
      do begin
         tick;
         guard++;
      end while (!frame_start && guard < 4096);
   endtask

   task automatic program_cfg(input int p, input int m);
      wr_period = 1'b1; period_in = W'(p);
      wr_mark   = 1'b1; mark_in   = W'(m);
      tick;
      wr_period = 1'b0; wr_mark = 1'b0;
      sync_frame;
   endtask

   // Called at the negedge inside the first cycle of a frame; returns at the
   // negedge inside the first cycle of the next frame.
   task automatic measure_frame(input int exp_len, input int exp_hi, input string tag,
                                input bit do_wr, input int np, input int nm,
                                input int stall);
      int  cnt = 0;
      int  hi = 0;
      bit  prev = 1'b0;
      bit  fallen = 1'b0;
      bit  rerise = 1'b0;
      bit  stall_ok = 1'b1;
      check(frame_start == 1'b1, "R2", int'(frame_start), 1);
      do begin
         if (cnt > 0 && prev && !pwm_out) fallen = 1'b1;
         if (pwm_out && fallen) rerise = 1'b1;
         if (pwm_out) hi++;
         prev = pwm_out;
         cnt++;
         if (do_wr && cnt == 1) begin
            wr_period = 1'b1; period_in = W'(np);
            wr_mark   = 1'b1; mark_in   = W'(nm);
         end
         if (stall > 0 && cnt == 2) begin
            en = 1'b0;
            for (int k = 0; k < stall; k++) begin
               tick;
               if (pwm_out != prev || frame_start) stall_ok = 1'b0;
            end
            en = 1'b1;
         end
         tick;
         wr_period = 1'b0; wr_mark = 1'b0;
      end while (!frame_start && cnt < 4096);
      check(cnt == exp_len, (stall > 0) ? "R7" : "R2", cnt, exp_len);
      check(hi == exp_hi, tag, hi, exp_hi);
      check(!rerise, "R8", int'(rerise), 0);
      if (stall > 0) check(stall_ok, "R7", int'(stall_ok), 1);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) tick;
      // R1: reset state
      check(pwm_out == 1'b0, "R1", int'(pwm_out), 0);
      check(frame_start == 1'b0, "R1", int'(frame_start), 0);
      rst = 1'b0;
      en  = 1'b1;
      tick;
      check(frame_start == 1'b1, "R1", int'(frame_start), 1);
      check(pwm_out == 1'b1, "R1", int'(pwm_out), 1);
      // Reset-value settings: period 9, mark 3
      measure_frame(10, 3, "R1", 1'b0, 0, 0, 0);

      program_cfg(5, 2);   measure_frame(6, 2, "R3", 1'b0, 0, 0, 0);
      program_cfg(5, 1);   measure_frame(6, 1, "R3", 1'b0, 0, 0, 0);
      program_cfg(5, 5);   measure_frame(6, 5, "R3", 1'b0, 0, 0, 0);
      program_cfg(5, 0);   measure_frame(6, 0, "R4", 1'b0, 0, 0, 0);
      measure_frame(6, 0, "R4", 1'b0, 0, 0, 0);
      program_cfg(5, 6);   measure_frame(6, 6, "R5", 1'b0, 0, 0, 0);
      program_cfg(5, 255); measure_frame(6, 6, "R5", 1'b0, 0, 0, 0);
      program_cfg(0, 0);   measure_frame(1, 0, "R9", 1'b0, 0, 0, 0);
      measure_frame(1, 0, "R9", 1'b0, 0, 0, 0);
      program_cfg(0, 1);   measure_frame(1, 1, "R9", 1'b0, 0, 0, 0);
      measure_frame(1, 1, "R9", 1'b0, 0, 0, 0);
      program_cfg(0, 200); measure_frame(1, 1, "R9", 1'b0, 0, 0, 0);
      program_cfg(30, 1);  measure_frame(31, 1, "R8", 1'b0, 0, 0, 0);

      // R6: mid-frame write leaves the running frame alone
      program_cfg(20, 7);
      measure_frame(21, 7, "R6", 1'b1, 4, 3, 0);
      measure_frame(5, 3, "R6", 1'b0, 0, 0, 0);

      // R7: enable low stretches the frame and freezes the output
      program_cfg(12, 5);
      measure_frame(13, 5, "R7", 1'b0, 0, 0, 7);
      program_cfg(12, 0);
      measure_frame(13, 0, "R7", 1'b0, 0, 0, 3);

      // Seeded random sweep of settings
      for (int i = 0; i < 40; i++) begin
         int p;
         int m;
         p = int'($urandom_range(0, 40));
         m = int'($urandom_range(0, 48));
         program_cfg(p, m);
         measure_frame(p + 1, exp_high(p, m), (m > p) ? "R5" : ((m == 0) ? "R4" : "R3"),
                       1'b0, 0, 0, 0);
         measure_frame(p + 1, exp_high(p, m), "R3", 1'b0, 0, 0, (p >= 2) ? 2 : 0);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

endmodule